// File: doc/BRIEF.md
# Clock-Master Synchronous Serial Port

This block is a UART-framed serial port that acts as a clock master. Each word goes out on `txd` as a start bit, then 8 or 9 data bits with the LSB first, then a stop bit. Next to the data line the block drives a serial clock on `sck`, so that external shift-register parts can latch the data bits. The clock gives one pulse per data bit and nothing else. It stays at its idle level through the start bit, the stop bit, idle time and break frames. A configuration bit chooses whether the final data bit, the address-mark position, also gets a pulse.

While the master clocks a frame out, it takes `rxd` in. It takes a single sample per data bit on the capture edge, at mid-bit, with no oversampling and no vote. Bit timing comes from a divider with an integer part `div_mant` and a fraction `div_frac` in sixteenths. This gives a sub-bit tick, and a bit lasts sixteen of these ticks. With a zero fraction the capture edge sits one sub-tick from a tick boundary on each side, so the receive setup and hold window is 1/16 of a bit. With a non-zero fraction the spacing of the ticks varies, and a 4/16 bit window must then be allowed. `div_mant` must be at least 1.

The clock idle level, the clock phase, the last-bit pulse and the word length are taken from the inputs only while both the transmitter and the receiver are off. When both are off, the output enables of `txd` and `sck` are low, so the pins float. The block is only ever a clock master: `sck` is always driven by the block.

Top module: `sync_serial_master`

## Requirements
- R1: After reset, and whenever no frame is running, `txd` is 1, `sck` sits at the latched polarity level, and `tx_ready` equals `tx_en`.
- R2: A frame is a start bit (0), then N data bits sent LSB first (N = 9 when the long-word setting is 1, else 8), then a stop bit (1). With `div_frac` = 0, each bit lasts exactly 16·`div_mant` clock cycles.
- R3: `sck` has no pulse during the start bit or the stop bit.
- R4: Each data bit except the last gets exactly one clock pulse. The last data bit gets one pulse when the last-bit setting is 1 and none when it is 0.
- R5: The idle level of `sck` is the polarity setting. With phase 0 the pulse fills the second half of the bit, so the leading edge is at mid-bit. With phase 1 the pulse fills the first half, so the leading edge is at the bit boundary. In both cases the capture edge is at mid-bit.
- R6: When `rx_en` is 1, `rxd` is sampled once per data bit, at the mid-bit capture edge. Levels that are away from that point are ignored. When `rx_en` is 0, nothing is received.
- R7: After the last data bit has been sampled, `rx_ready` rises and `rx_data` holds the word with the first received bit at bit 0. In 8-bit mode bit 8 of `rx_data` is 0.
- R8: If a word completes while `rx_ready` is still 1 and `rx_ack` is 0, `rx_overrun` rises and `rx_data` keeps the older word. `rx_ack` clears both `rx_ready` and `rx_overrun`.
- R9: A break request sends 0 for the start bit and all N data bits, then a stop bit of 1. It gives no clock pulses and leaves the receiver unchanged.
- R10: One cycle after `tx_en` and `rx_en` are both 0, `txd_oe` and `sck_oe` are 0. While either enable is 1, both output enables are 1.
- R11: Polarity, phase, last-bit and word-length settings are latched only while both enables are 0. Changes made while either enable is 1 have no effect.
- R12: With a fractional divider, every bit lasts exactly 16·`div_mant` + `div_frac` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| cfg_cpol | input | 1 | Clock idle level |
| cfg_cpha | input | 1 | Clock phase select |
| cfg_lastclk | input | 1 | Pulse on the final data bit |
| cfg_long | input | 1 | 1 = 9-bit words, 0 = 8-bit words |
| div_mant | input | MANT_W | Divider integer part (≥ 1) |
| div_frac | input | FRAC_W | Divider fraction in sixteenths |
| tx_valid | input | 1 | Word or break request offered |
| tx_brk | input | 1 | The request is a break frame |
| tx_data | input | DW | Word to send, LSB first |
| tx_ready | output | 1 | Request accepted this cycle if valid |
| rxd | input | 1 | Serial receive data |
| rx_ack | input | 1 | Consume received word |
| txd | output | 1 | Serial transmit data |
| txd_oe | output | 1 | Output enable for `txd` |
| sck | output | 1 | Serial clock |
| sck_oe | output | 1 | Output enable for `sck` |
| rx_data | output | DW | Last received word |
| rx_ready | output | 1 | A received word is waiting |
| rx_overrun | output | 1 | A word was lost |

## Verification
`txd` and `sck` both come out of one register stage after the sequencer state, so they line up cycle for cycle. The bench records both pins every cycle and measures all bit positions from the cycle in which `txd` first goes low. Each bit is sampled at 1/4, 1/2 and 3/4 of its length, well clear of any edge. The receive data is driven as a function of that same recorded start cycle, and it is corrupted outside the middle half of each bit. `rx_ready` and `rx_data` are checked only once the whole frame has ended, which is many cycles after the capture. The output enables are checked two cycles after the enables change, which gives one cycle of margin over the single register stage.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_ARM  = 2'd1,
    SQ_RUN  = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic cpol;
    logic cpha;
    logic lastclk;
    logic longw;
  } line_cfg_t;

endpackage

// File: rtl/ssm_cfg_hold.sv
module ssm_cfg_hold
  import ssm_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      tx_en,
  input  logic      rx_en,
  input  line_cfg_t cfg_in,
  output line_cfg_t cfg_q
);

  logic any_on;
  assign any_on = tx_en | rx_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (!any_on) begin
      cfg_q <= cfg_in;
    end
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    any_on |=> $stable(cfg_q)); // R11

endmodule

// File: rtl/ssm_tick_gen.sv
module ssm_tick_gen #(
  parameter int MANT_W = 12,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MANT_W-1:0] mant,
  input  logic [FRAC_W-1:0] frac,
  output logic              tick
);

  localparam int DIV_W = MANT_W + FRAC_W;
  localparam int ACC_W = DIV_W + 1;
  localparam int STEP  = 1 << FRAC_W;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_sum;
  logic [ACC_W-1:0] div_full;

  always_comb begin
    div_full = ACC_W'({mant, frac});
    acc_sum  = acc_q + ACC_W'(STEP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      tick  <= 1'b0;
    end else if (acc_sum >= div_full) begin
      acc_q <= acc_sum - div_full;
      tick  <= 1'b1;
    end else begin
      acc_q <= acc_sum;
      tick  <= 1'b0;
    end
  end

endmodule

// File: rtl/ssm_frame_seq.sv
module ssm_frame_seq
  import ssm_pkg::*;
#(
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          tx_en,
  input  line_cfg_t     cfg,
  input  logic          tx_valid,
  input  logic          tx_brk,
  input  logic [DW-1:0] tx_data,
  output logic          tx_ready,
  output logic          txd,
  output logic          sck,
  output logic          cap_stb,
  output logic          cap_last
);

  localparam int IDX_W = $clog2(DW + 2);
  localparam logic [3:0] SUB_LAST = 4'd15;
  localparam logic [3:0] SUB_CAP  = 4'd7;

  seq_state_e     st_q;
  logic [3:0]     sub_q;
  logic [IDX_W-1:0] idx_q;
  logic [DW-1:0]  sh_q;
  logic           brk_q;

  logic [IDX_W-1:0] last_idx;
  logic [IDX_W-1:0] stop_idx;
  logic           running;
  logic           in_data;
  logic           pulse_bit;
  logic           half_on;
  logic           txd_d;
  logic           sck_d;

  always_comb begin
    last_idx  = cfg.longw ? IDX_W'(DW) : IDX_W'(DW - 1);
    stop_idx  = last_idx + IDX_W'(1);
    running   = (st_q == SQ_RUN);
    in_data   = running && (idx_q != '0) && (idx_q <= last_idx);
    pulse_bit = in_data && !brk_q && ((idx_q != last_idx) || cfg.lastclk);
    half_on   = cfg.cpha ? !sub_q[3] : sub_q[3];
    sck_d     = cfg.cpol ^ (pulse_bit && half_on);
    if (!running)            txd_d = 1'b1;
    else if (idx_q == '0)    txd_d = 1'b0;
    else if (in_data)        txd_d = brk_q ? 1'b0 : sh_q[0];
    else                     txd_d = 1'b1;
    cap_stb  = tick && in_data && !brk_q && (sub_q == SUB_CAP);
    cap_last = (idx_q == last_idx);
    tx_ready = (st_q == SQ_IDLE) && tx_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= SQ_IDLE;
      sub_q <= '0;
      idx_q <= '0;
      sh_q  <= '0;
      brk_q <= 1'b0;
      txd   <= 1'b1;
      sck   <= 1'b0;
    end else begin
      txd <= txd_d;
      sck <= sck_d;
      case (st_q)
        SQ_IDLE: begin
          if (tx_valid && tx_ready) begin
            sh_q  <= tx_data;
            brk_q <= tx_brk;
            st_q  <= SQ_ARM;
          end
        end
        SQ_ARM: begin
          if (tick) begin
            st_q  <= SQ_RUN;
            sub_q <= '0;
            idx_q <= '0;
          end
        end
        SQ_RUN: begin
          if (tick) begin
            sub_q <= sub_q + 4'd1;
            if (sub_q == SUB_LAST) begin
              if (idx_q == stop_idx) begin
                st_q <= SQ_IDLE;
              end else begin
                idx_q <= idx_q + IDX_W'(1);
              end
              if (in_data) sh_q <= {1'b0, sh_q[DW-1:1]};
            end
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  AST_IDLE_CLK_QUIET: assert property (@(posedge clk) disable iff (rst)
    (st_q != SQ_RUN) |=> (sck == $past(cfg.cpol))); // R1
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (st_q != SQ_RUN) |=> txd); // R1
  AST_NO_CLK_START_STOP: assert property (@(posedge clk) disable iff (rst)
    (running && ((idx_q == '0) || (idx_q == stop_idx))) |=> (sck == $past(cfg.cpol))); // R3
  AST_BRK_NO_CLK: assert property (@(posedge clk) disable iff (rst)
    (running && brk_q) |=> (sck == $past(cfg.cpol))); // R9

endmodule

// File: rtl/ssm_rx_capture.sv
module ssm_rx_capture #(
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_en,
  input  logic          longw,
  input  logic          rxd,
  input  logic          cap_stb,
  input  logic          cap_last,
  input  logic          rx_ack,
  output logic [DW-1:0] rx_data,
  output logic          rx_ready,
  output logic          rx_overrun
);

  logic [DW-1:0] sh_q;
  logic [DW-1:0] word;
  logic [DW-1:0] word_al;
  logic          take;
  logic          done;

  always_comb begin
    word    = {rxd, sh_q[DW-1:1]};
    word_al = longw ? word : (word >> 1);
    take    = cap_stb && rx_en;
    done    = take && cap_last;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q       <= '0;
      rx_data    <= '0;
      rx_ready   <= 1'b0;
      rx_overrun <= 1'b0;
    end else begin
      if (take) sh_q <= word;
      if (rx_ack) begin
        rx_ready   <= 1'b0;
        rx_overrun <= 1'b0;
      end
      if (done) begin
        if (rx_ready && !rx_ack) begin
          rx_overrun <= 1'b1;
        end else begin
          rx_data  <= word_al;
          rx_ready <= 1'b1;
        end
      end
    end
  end

  AST_OVR_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
    rx_overrun |-> rx_ready); // R8
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
    (rx_ready && !rx_ack) |=> $stable(rx_data)); // R8

endmodule

// File: rtl/sync_serial_master.sv
module sync_serial_master
  import ssm_pkg::*;
#(
  parameter int DW     = 9,
  parameter int MANT_W = 12,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_lastclk,
  input  logic              cfg_long,
  input  logic [MANT_W-1:0] div_mant,
  input  logic [FRAC_W-1:0] div_frac,
  input  logic              tx_valid,
  input  logic              tx_brk,
  input  logic [DW-1:0]     tx_data,
  output logic              tx_ready,
  input  logic              rxd,
  input  logic              rx_ack,
  output logic              txd,
  output logic              txd_oe,
  output logic              sck,
  output logic              sck_oe,
  output logic [DW-1:0]     rx_data,
  output logic              rx_ready,
  output logic              rx_overrun
);

  line_cfg_t cfg_in;
  line_cfg_t cfg_q;
  logic      tick;
  logic      cap_stb;
  logic      cap_last;
  logic      oe_q;

  always_comb begin
    cfg_in.cpol    = cfg_cpol;
    cfg_in.cpha    = cfg_cpha;
    cfg_in.lastclk = cfg_lastclk;
    cfg_in.longw   = cfg_long;
  end

  ssm_cfg_hold u_cfg (
    .clk    (clk),
    .rst    (rst),
    .tx_en  (tx_en),
    .rx_en  (rx_en),
    .cfg_in (cfg_in),
    .cfg_q  (cfg_q)
  );

  ssm_tick_gen #(.MANT_W(MANT_W), .FRAC_W(FRAC_W)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .mant (div_mant),
    .frac (div_frac),
    .tick (tick)
  );

  ssm_frame_seq #(.DW(DW)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .tx_en    (tx_en),
    .cfg      (cfg_q),
    .tx_valid (tx_valid),
    .tx_brk   (tx_brk),
    .tx_data  (tx_data),
    .tx_ready (tx_ready),
    .txd      (txd),
    .sck      (sck),
    .cap_stb  (cap_stb),
    .cap_last (cap_last)
  );

  ssm_rx_capture #(.DW(DW)) u_rx (
    .clk        (clk),
    .rst        (rst),
    .rx_en      (rx_en),
    .longw      (cfg_q.longw),
    .rxd        (rxd),
    .cap_stb    (cap_stb),
    .cap_last   (cap_last),
    .rx_ack     (rx_ack),
    .rx_data    (rx_data),
    .rx_ready   (rx_ready),
    .rx_overrun (rx_overrun)
  );

  always_ff @(posedge clk) begin
    if (rst) oe_q <= 1'b0;
    else     oe_q <= tx_en | rx_en;
  end

  assign txd_oe = oe_q;
  assign sck_oe = oe_q;

  AST_HIZ_OFF: assert property (@(posedge clk) disable iff (rst)
    (!tx_en && !rx_en) |=> (!txd_oe && !sck_oe)); // R10
  AST_OE_ON: assert property (@(posedge clk) disable iff (rst)
    (tx_en || rx_en) |=> (txd_oe && sck_oe)); // R10

endmodule

// File: tb/sync_serial_master_tb.sv
module sync_serial_master_tb_top;

  localparam int LOGN = 1024;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_en = 1'b0, rx_en = 1'b0;
  logic       cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lastclk = 1'b0, cfg_long = 1'b0;
  logic [11:0] div_mant = 12'd2;
  logic [3:0]  div_frac = 4'd0;
  logic       tx_valid = 1'b0, tx_brk = 1'b0;
  logic [8:0] tx_data = '0;
  logic       tx_ready;
  logic       rxd = 1'b1;
  logic       rx_ack = 1'b0;
  logic       txd, txd_oe, sck, sck_oe;
  logic [8:0] rx_data;
  logic       rx_ready, rx_overrun;

  int checks = 0;
  int errs = 0;
  bit done = 1'b0;

  logic lt [LOGN];
  logic ls [LOGN];
  int   n = 0;
  int   t0 = 0;
  bit   rec_on = 1'b0;
  bit   seen = 1'b0;
  int   bt = 32;
  int   nb = 8;
  logic [8:0] rx_word = '0;

  always #4 clk = ~clk;

  sync_serial_master dut_i (
    .clk(clk), .rst(rst), .tx_en(tx_en), .rx_en(rx_en),
    .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_lastclk(cfg_lastclk), .cfg_long(cfg_long),
    .div_mant(div_mant), .div_frac(div_frac),
    .tx_valid(tx_valid), .tx_brk(tx_brk), .tx_data(tx_data), .tx_ready(tx_ready),
    .rxd(rxd), .rx_ack(rx_ack), .txd(txd), .txd_oe(txd_oe), .sck(sck), .sck_oe(sck_oe),
    .rx_data(rx_data), .rx_ready(rx_ready), .rx_overrun(rx_overrun)
  );

  // Pin recorder and slave-side receive driver (garbage outside the mid half of each bit)
  always @(negedge clk) begin
    if (rec_on) begin
      int c, k, pos;
      logic bv;
      if (n < LOGN) begin
        lt[n] = txd;
        ls[n] = sck;
      end
      if (!seen && txd === 1'b0) begin
        seen = 1'b1;
        t0 = n;
      end
      if (seen) begin
        c = n - t0;
        k = c / bt;
        pos = c % bt;
        bv = (k >= 1 && k <= nb) ? rx_word[k-1] : 1'b1;
        rxd = (pos >= bt / 4 && pos < (3 * bt) / 4) ? bv : ~bv;
      end
      n++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(input bit cp, input bit ph, input bit lc, input bit lw);
    @(negedge clk);
    tx_en = 1'b0; rx_en = 1'b0;
    cfg_cpol = cp; cfg_cpha = ph; cfg_lastclk = lc; cfg_long = lw;
    repeat (2) @(negedge clk);
    chk(!txd_oe && !sck_oe, "R10", {txd_oe, sck_oe}, 0, "oe while disabled");
    tx_en = 1'b1; rx_en = 1'b1;
    repeat (2) @(negedge clk);
    chk(txd_oe && sck_oe, "R10", {txd_oe, sck_oe}, 3, "oe while enabled");
    chk(sck == cp, "R5", sck, cp, "idle clock level");
  endtask

  task automatic send(input logic [8:0] d, input logic [8:0] rw, input bit brk, input int nbits, input int bitlen);
    rx_word = rw; nb = nbits; bt = bitlen;
    seen = 1'b0; n = 0; rec_on = 1'b1;
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1; tx_data = d; tx_brk = brk;
    @(negedge clk);
    tx_valid = 1'b0; tx_brk = 1'b0;
    repeat ((nbits + 3) * bitlen + 8) @(negedge clk);
    rec_on = 1'b0;
    rxd = 1'b1;
  endtask

  task automatic analyze(input logic [8:0] d, input bit brk, input bit cp, input bit ph, input bit lc, input int nbits);
    int base, cnt, expp;
    string rq;
    logic expt;
    chk(seen, "R2", seen, 1, "start bit seen");
    if (!seen) return;
    chk(lt[t0-1] === 1'b1, "R1", lt[t0-1], 1, "line idle before start");
    chk(ls[t0-1] === cp, "R5", ls[t0-1], cp, "clock idle before start");
    for (int k = 0; k <= nbits + 1; k++) begin
      base = t0 + k * bt;
      if (k == 0) expt = 1'b0;
      else if (k <= nbits) expt = brk ? 1'b0 : d[k-1];
      else expt = 1'b1;
      chk(lt[base + bt/2] === expt, brk ? "R9" : "R2", lt[base + bt/2], expt, $sformatf("txd bit slot %0d", k));
      cnt = 0;
      for (int i = base; i < base + bt; i++)
        if (ls[i] !== cp && ls[i-1] === cp) cnt++;
      expp = (!brk && k >= 1 && k <= nbits && (k != nbits || lc)) ? 1 : 0;
      if (brk) rq = "R9";
      else if (k == 0 || k == nbits + 1) rq = "R3";
      else rq = "R4";
      chk(cnt == expp, rq, cnt, expp, $sformatf("pulses in slot %0d", k));
      if (expp == 1) begin
        chk(ls[base + bt/4] === (cp ^ ph), "R5", ls[base + bt/4], cp ^ ph, $sformatf("first half level slot %0d", k));
        chk(ls[base + (3*bt)/4] === (cp ^ !ph), "R5", ls[base + (3*bt)/4], cp ^ !ph, $sformatf("second half level slot %0d", k));
      end
    end
  endtask

  task automatic ack;
    @(negedge clk); rx_ack = 1'b1;
    @(negedge clk); rx_ack = 1'b0;
    @(negedge clk);
  endtask

  task automatic rx_expect(input logic [8:0] w, input int nbits);
    logic [8:0] m;
    m = (nbits == 9) ? w : {1'b0, w[7:0]};
    chk(rx_ready === 1'b1, "R7", rx_ready, 1, "ready after frame");
    chk(rx_data === m, "R6", rx_data, m, "captured word");
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin : main
    logic [8:0] d, w, a, b;
    int nbits, rise, fall;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(txd === 1'b1, "R1", txd, 1, "reset txd");
    chk(sck === 1'b0, "R1", sck, 0, "reset sck");
    chk(tx_ready === 1'b0, "R1", tx_ready, 0, "reset ready with tx off");
    chk(!txd_oe && !sck_oe, "R10", {txd_oe, sck_oe}, 0, "reset oe");
    chk(rx_ready === 1'b0 && rx_overrun === 1'b0, "R7", {rx_ready, rx_overrun}, 0, "reset rx flags");

    // Full sweep of polarity, phase, last-bit pulse and word length
    for (int c = 0; c < 16; c++) begin
      set_cfg(c[0], c[1], c[2], c[3]);
      nbits = c[3] ? 9 : 8;
      chk(tx_ready === 1'b1, "R1", tx_ready, 1, "ready when idle");
      for (int f = 0; f < 2; f++) begin
        d = 9'((f == 0) ? (c * 37 + 11) : (c * 91 + 300));
        w = 9'((f == 0) ? (c * 53 + 170) : (c * 29 + 77));
        if (nbits == 8) d[8] = 1'b0;
        send(d, w, 1'b0, nbits, 32);
        analyze(d, 1'b0, c[0], c[1], c[2], nbits);
        rx_expect(w, nbits);
        ack();
        chk(rx_ready === 1'b0, "R8", rx_ready, 0, "ack clears ready");
      end
    end

    // Overrun: second word lost while first unread
    set_cfg(1'b0, 1'b0, 1'b1, 1'b0);
    a = 9'h05A; b = 9'h0C3;
    send(9'h011, a, 1'b0, 8, 32);
    send(9'h022, b, 1'b0, 8, 32);
    chk(rx_overrun === 1'b1, "R8", rx_overrun, 1, "overrun flagged");
    chk(rx_data === a, "R8", rx_data, a, "older word kept");
    ack();
    chk(rx_ready === 1'b0 && rx_overrun === 1'b0, "R8", {rx_ready, rx_overrun}, 0, "ack clears both");
    send(9'h033, 9'h0E7, 1'b0, 8, 32);
    rx_expect(9'h0E7, 8);
    chk(rx_overrun === 1'b0, "R8", rx_overrun, 0, "no overrun after ack");
    ack();

    // Break frame: no clock, receiver untouched
    send(9'h0FF, 9'h0AA, 1'b1, 8, 32);
    analyze(9'h0FF, 1'b1, 1'b0, 1'b0, 1'b1, 8);
    chk(rx_ready === 1'b0, "R9", rx_ready, 0, "break leaves receiver");

    // Receiver off: nothing captured
    @(negedge clk); rx_en = 1'b0;
    send(9'h0F0, 9'h055, 1'b0, 8, 32);
    chk(rx_ready === 1'b0, "R6", rx_ready, 0, "no capture with rx off");
    rx_en = 1'b1;

    // Settings changed while enabled are ignored
    set_cfg(1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    cfg_cpol = 1'b1; cfg_cpha = 1'b1; cfg_lastclk = 1'b1; cfg_long = 1'b1;
    repeat (3) @(negedge clk);
    chk(sck === 1'b0, "R11", sck, 0, "polarity change ignored");
    send(9'h1C9, 9'h136, 1'b0, 8, 32);
    analyze(9'h0C9, 1'b0, 1'b0, 1'b0, 1'b0, 8);
    rx_expect(9'h036, 8);
    ack();
    set_cfg(1'b1, 1'b1, 1'b1, 1'b1);
    send(9'h1C9, 9'h136, 1'b0, 9, 32);
    analyze(9'h1C9, 1'b0, 1'b1, 1'b1, 1'b1, 9);
    rx_expect(9'h136, 9);
    ack();

    // Fractional divider: bit length 16*2+5 = 37
    @(negedge clk); tx_en = 1'b0; rx_en = 1'b0;
    div_frac = 4'd5;
    set_cfg(1'b0, 1'b0, 1'b1, 1'b0);
    send(9'h001, 9'h000, 1'b0, 8, 37);
    rise = -1; fall = -1;
    for (int i = t0; i < n && i < LOGN; i++) begin
      if (rise < 0 && lt[i] === 1'b1) rise = i - t0;
      else if (rise >= 0 && fall < 0 && lt[i] === 1'b0) fall = i - t0;
    end
    chk(rise == 37, "R12", rise, 37, "start bit length");
    chk(fall == 74, "R12", fall, 74, "first data bit end");
    ack();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule